// File: doc/BRIEF.md
# Per-Channel Clock Blocking Generator

This block drives one blocking output for a T1 framer data path. Software programs 24 channel bits through a small register write port, using three 8-bit registers. A position counter follows the serial bit clock and restarts on a frame sync pulse. The output then tracks the programmed bit for the whole span of each channel. Downstream logic uses it to gate the clock of a serial controller so that it sees only selected channels.

In T1 (1.544 MHz) mode a frame is 193 bit periods: a framing bit, then 24 channels of 8 bits. In E1-rate (2.048 MHz) mode a frame is 32 timeslots of 8 bits. Every fourth timeslot, counted from 0, is blocked unconditionally. The 24 channels fill the other timeslots in order. A write lands in a staging copy and reaches the output only at the next frame boundary, so no frame is ever partly reprogrammed. The receive and transmit sides each use their own instance, with their own registers and output.

The block has no streaming data interface. All of its pins are plain control and status signals with no valid/ready handshake, and a register write is accepted in the cycle it is presented.

Top module: `chan_block_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `blk_out` is 0, and all 24 channel bits read as 0.
- R2: Address 0 holds channels 1 to 8, address 1 holds channels 9 to 16 and address 2 holds channels 17 to 24. Within each register, bit 0 is the lowest-numbered channel and bit 7 the highest.
- R3: With `e1_mode`=0 a frame is 193 positions. At position 0 (the framing bit) `blk_out` is 0. At positions 8(c-1)+1 to 8c, `blk_out` equals the bit of channel c. After position 192 the count wraps to position 0.
- R4: With `e1_mode`=1 a frame is 256 positions, and timeslot t covers positions 8t to 8t+7. When t is 0, 4, 8, ..., 28, `blk_out` is 1 whatever the channel bits are. After position 255 the count wraps to position 0.
- R5: With `e1_mode`=1 the non-forced timeslots carry channels 1 to 24 in ascending order. Timeslot t (t not a multiple of 4) shows channel t - floor(t/4).
- R6: If `frame_sync` is high in cycle N, then `blk_out` in cycle N+1 shows position 0, and the frame runs on freely from there.
- R7: A register write reaches `blk_out` only from the next frame boundary, which is a wrap or a sync. A write presented in the same cycle as a boundary takes effect one full frame later.
- R8: A write to address 3 changes no channel bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (line rate or system rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | One-cycle pulse; the next cycle is frame position 0 |
| e1_mode | input | 1 | 0: 193-bit T1 frame, 1: 256-bit E1-rate frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0..2 valid) |
| reg_wdata | input | 8 | Register write data |
| blk_out | output | 1 | Registered blocking output |

## Verification
Two functions can fall in the same cycle: a register write and a frame boundary. The bench drives the write strobe together with the frame sync pulse. It expects the old pattern for the whole following frame and the new pattern in the frame after. A second case writes in the middle of a frame and checks that the rest of that frame is unchanged. In E1-rate mode the forced timeslots coincide with fully set channel registers, and the bench checks that the forcing wins while the channel bits still fill the remaining timeslots.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
  // Frame layout shared by all pieces of the generator
  typedef enum logic {
    MODE_T1 = 1'b0,
    MODE_E1 = 1'b1
  } sys_mode_e;

  function automatic int frame_len(input sys_mode_e mode, input int nch,
                                   input int bits, input int slots);
    return (mode == MODE_E1) ? slots * bits : nch * bits + 1;
  endfunction
endpackage

// File: rtl/cbg_regs.sv
module cbg_regs #(
  parameter int REG_W    = 8,
  parameter int NUM_REGS = 3,
  parameter int ADDR_W   = 2,
  parameter int NUM_CH   = NUM_REGS * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              boundary,
  output logic [NUM_CH-1:0] active
);
  logic [NUM_REGS-1:0][REG_W-1:0] staged_q;
  logic [NUM_REGS-1:0][REG_W-1:0] active_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        staged_q[r] <= '0;
        active_q[r] <= '0;
      end else begin
        if (wr && addr == ADDR_W'(r)) staged_q[r] <= wdata;
        if (boundary) active_q[r] <= staged_q[r];
      end
    end
  end

  assign active = active_q;

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(active_q)); // R7
  AST_ACTIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> active_q == $past(staged_q)); // R7
endmodule

// File: rtl/cbg_counter.sv
module cbg_counter
  import cbg_pkg::*;
#(
  parameter int BITS_PER_CH = 8,
  parameter int NUM_CH      = 24,
  parameter int E1_SLOTS    = 32,
  parameter int POS_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_sync,
  input  logic             e1_mode,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] pos_next,
  output logic             boundary
);
  localparam int T1_LEN = frame_len(MODE_T1, NUM_CH, BITS_PER_CH, E1_SLOTS);
  localparam int E1_LEN = frame_len(MODE_E1, NUM_CH, BITS_PER_CH, E1_SLOTS);

  logic [POS_W-1:0] last_pos;

  assign last_pos = e1_mode ? POS_W'(E1_LEN - 1) : POS_W'(T1_LEN - 1);
  assign pos_next = frame_sync ? '0 :
                    (pos >= last_pos) ? '0 : pos + 1'b1;
  assign boundary = (pos_next == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) pos <= '0;
    else        pos <= pos_next;
  end

  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> pos == '0); // R6
  AST_T1_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!e1_mode && pos == POS_W'(T1_LEN - 1)) |=> pos == '0); // R3
endmodule

// File: rtl/cbg_decode.sv
module cbg_decode #(
  parameter int BITS_PER_CH  = 8,
  parameter int NUM_CH       = 24,
  parameter int FORCE_STRIDE = 4,
  parameter int POS_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e1_mode,
  input  logic [POS_W-1:0]  pos,
  input  logic [POS_W-1:0]  pos_next,
  input  logic [NUM_CH-1:0] active,
  output logic              blk_out
);
  localparam int CH_W = $clog2(NUM_CH);

  int   p_i, ch_t1, slot, ch_e1;
  logic forced, blk_next;

  always_comb begin
    p_i      = int'(pos_next);
    ch_t1    = (p_i - 1) / BITS_PER_CH;
    slot     = p_i / BITS_PER_CH;
    forced   = (slot % FORCE_STRIDE) == 0;
    ch_e1    = slot - (slot / FORCE_STRIDE) - 1;
    blk_next = 1'b0;
    if (e1_mode) begin
      if (forced)               blk_next = 1'b1;
      else if (ch_e1 < NUM_CH)  blk_next = active[CH_W'(ch_e1)];
    end else if (p_i != 0 && ch_t1 < NUM_CH) begin
      blk_next = active[CH_W'(ch_t1)];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) blk_out <= 1'b0;
    else        blk_out <= blk_next;
  end

  AST_FBIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!e1_mode) && pos == '0) |-> !blk_out); // R3
  AST_E1_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(e1_mode) &&
     ((int'(pos) / BITS_PER_CH) % FORCE_STRIDE) == 0) |-> blk_out); // R4
endmodule

// File: rtl/chan_block_gen.sv
module chan_block_gen
  import cbg_pkg::*;
#(
  parameter int REG_W        = 8,
  parameter int NUM_REGS     = 3,
  parameter int ADDR_W       = 2,
  parameter int BITS_PER_CH  = 8,
  parameter int E1_SLOTS     = 32,
  parameter int FORCE_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              e1_mode,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic              blk_out
);
  localparam int NUM_CH  = NUM_REGS * REG_W;
  localparam int T1_LEN  = frame_len(MODE_T1, NUM_CH, BITS_PER_CH, E1_SLOTS);
  localparam int E1_LEN  = frame_len(MODE_E1, NUM_CH, BITS_PER_CH, E1_SLOTS);
  localparam int MAX_LEN = (E1_LEN > T1_LEN) ? E1_LEN : T1_LEN;
  localparam int POS_W   = $clog2(MAX_LEN);

  logic [POS_W-1:0]  pos, pos_next;
  logic              boundary;
  logic [NUM_CH-1:0] active;

  cbg_counter #(
    .BITS_PER_CH(BITS_PER_CH), .NUM_CH(NUM_CH),
    .E1_SLOTS(E1_SLOTS), .POS_W(POS_W)
  ) u_counter (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .e1_mode(e1_mode),
    .pos(pos), .pos_next(pos_next), .boundary(boundary)
  );

  cbg_regs #(
    .REG_W(REG_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .boundary(boundary), .active(active)
  );

  cbg_decode #(
    .BITS_PER_CH(BITS_PER_CH), .NUM_CH(NUM_CH),
    .FORCE_STRIDE(FORCE_STRIDE), .POS_W(POS_W)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .e1_mode(e1_mode), .pos(pos),
    .pos_next(pos_next), .active(active), .blk_out(blk_out)
  );
endmodule

// File: tb/chan_block_gen_bench.sv
module chan_block_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_sync = 1'b0;
  logic       e1_mode = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       blk_out;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  chan_block_gen u_chan_block_gen (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .e1_mode(e1_mode),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .blk_out(blk_out)
  );

  // Expected output for frame position k, from R3, R4 and R5
  function automatic logic expv(input int k, input logic e1, input logic [23:0] bits);
    int ts;
    if (!e1) return (k == 0) ? 1'b0 : bits[(k - 1) / 8];
    ts = k / 8;
    if ((ts % 4) == 0) return 1'b1;
    return bits[ts - ts / 4 - 1];
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic load_bits(input logic [23:0] bits);
    wr_reg(2'd0, bits[7:0]);
    wr_reg(2'd1, bits[15:8]);
    wr_reg(2'd2, bits[23:16]);
  endtask

  // Sync pulse, optionally with a write in the same cycle; ends at position 0
  task automatic sync_pulse(input logic e1, input bit do_wr,
                            input logic [1:0] a, input logic [7:0] d);
    e1_mode = e1;
    frame_sync = 1'b1;
    if (do_wr) begin reg_wr = 1'b1; reg_addr = a; reg_wdata = d; end
    @(negedge clk);
    frame_sync = 1'b0;
    reg_wr = 1'b0;
  endtask

  task automatic check_frame(input logic e1, input logic [23:0] bits, input int wk,
                             input logic [1:0] wa, input logic [7:0] wd,
                             input string tag);
    int len;
    logic e;
    len = e1 ? 256 : 193;
    for (int k = 0; k < len; k++) begin
      e = expv(k, e1, bits);
      nchk++;
      if (blk_out !== e) begin
        nbad++;
        $display("FAIL %s pos=%0d got=%b exp=%b", tag, k, blk_out, e);
      end
      if (k == wk) begin reg_wr = 1'b1; reg_addr = wa; reg_wdata = wd; end
      @(negedge clk);
      reg_wr = 1'b0;
    end
  endtask

  task automatic t_reset();
    nchk++;
    if (blk_out !== 1'b0) begin
      nbad++;
      $display("FAIL R1 reset got=%b exp=0", blk_out);
    end
    // R1: channel bits cleared, so a fresh T1 frame is all low
    sync_pulse(1'b0, 1'b0, 2'd0, 8'h00);
    check_frame(1'b0, 24'h0, -1, 2'd0, 8'h00, "R1 cleared bits");
  endtask

  task automatic t_t1(input logic [23:0] bits);
    load_bits(bits);
    sync_pulse(1'b0, 1'b0, 2'd0, 8'h00);
    check_frame(1'b0, bits, -1, 2'd0, 8'h00, "R2 R3 t1 frame");
    check_frame(1'b0, bits, -1, 2'd0, 8'h00, "R6 t1 wrap frame");
  endtask

  task automatic t_e1(input logic [23:0] bits);
    load_bits(bits);
    sync_pulse(1'b1, 1'b0, 2'd0, 8'h00);
    check_frame(1'b1, bits, -1, 2'd0, 8'h00, "R4 R5 e1 frame");
    check_frame(1'b1, bits, -1, 2'd0, 8'h00, "R4 e1 wrap frame");
  endtask

  task automatic t_midframe();
    load_bits(24'h12_34_56);
    sync_pulse(1'b0, 1'b0, 2'd0, 8'h00);
    check_frame(1'b0, 24'h12_34_56, 50, 2'd1, 8'hF0, "R7 midframe hold");
    check_frame(1'b0, 24'h12_F0_56, -1, 2'd0, 8'h00, "R7 midframe next");
  endtask

  task automatic t_collision();
    load_bits(24'h0F_0F_0F);
    sync_pulse(1'b0, 1'b0, 2'd0, 8'h00);
    check_frame(1'b0, 24'h0F_0F_0F, -1, 2'd0, 8'h00, "R7 before collision");
    sync_pulse(1'b0, 1'b1, 2'd2, 8'hC3);
    check_frame(1'b0, 24'h0F_0F_0F, -1, 2'd0, 8'h00, "R7 collision frame");
    check_frame(1'b0, 24'hC3_0F_0F, -1, 2'd0, 8'h00, "R7 after collision");
  endtask

  task automatic t_addr3();
    load_bits(24'h81_42_24);
    wr_reg(2'd3, 8'hFF);
    sync_pulse(1'b0, 1'b0, 2'd0, 8'h00);
    check_frame(1'b0, 24'h81_42_24, -1, 2'd0, 8'h00, "R8 addr3 ignored");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_t1(24'hA5_3C_81);
    t_t1(24'hFF_FF_FF);
    t_t1(24'h00_00_00);
    t_e1(24'h5A_C3_18);
    t_e1(24'hFF_FF_FF);
    t_e1(24'h00_00_00);
    t_midframe();
    t_collision();
    t_addr3();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nbad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule